// File: doc/BRIEF.md
# Boot-Latched Memory Access Router

This block sits between a CPU core and its memory system. For each access it decides whether the access goes to on-chip memory or to the external bus. It also drives two status signals for external bus cycles: an instruction-fetch indicator and an active-low read strobe. It does not contain the memory arrays, and it does not shape bus timing waveforms.

The routing of the program/special-purpose address window is set by a strap pin. The router samples the strap pin only while reset is held. The value it took at the last clock edge of reset stays in force until the next reset. While the strap selects external operation, the router tells the port logic that the two shared I/O ports must carry the multiplexed address/data bus.

An access is described by:
- a valid flag,
- an address,
- a two-bit kind code,
- a write flag.

The three cycle outputs are registered and appear one clock after the request.

Top module: `mem_access_router`

## Requirements
- R1: The strap level (`ext_mem_n`) is captured at the last rising clock edge on which `rst` is high. Changing `ext_mem_n` while `rst` is low affects no output.
- R2: With a captured strap of 1, addresses FF2000h through FF9FFFh inclusive (parameters `WIN_LO`/`WIN_HI`) are routed internally, so `cyc_ext` is 0.
- R3: With a captured strap of 0, addresses FF2000h through FF9FFFh are routed to the external bus, so `cyc_ext` is 1.
- R4: Addresses outside that window are external (`cyc_ext` = 1), except those in the register window 000000h–0003FFh (parameters `REG_LO`/`REG_HI`). Register-window addresses are internal regardless of the strap.
- R5: `ports_as_bus` is 1 exactly when the captured strap is 0.
- R6: An external read with kind code 2'b00 (instruction fetch) drives `fetch_stat` to 1.
- R7: External reads with kind 2'b01 (data), 2'b10 (interrupt vector) or 2'b11 (configuration byte) drive `fetch_stat` to 0. An external write also drives `fetch_stat` to 0, whatever its kind.
- R8: Any internal access leaves `fetch_stat` at 0, including an instruction fetch.
- R9: `rd_n` goes low only for external reads (`req_write` = 0). Writes and internal accesses leave it high.
- R10: `cyc_ext`, `fetch_stat` and `rd_n` are registered. They reflect the request presented one clock earlier. They are idle (0, 0, 1) while `rst` is high or when `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap is sampled while high |
| ext_mem_n | input | 1 | Strap pin: 1 = window internal, 0 = window external |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | 00 instruction, 01 data, 10 vector, 11 configuration byte |
| req_write | input | 1 | 1 = write, 0 = read |
| cyc_ext | output | 1 | Registered: previous access went to the external bus |
| fetch_stat | output | 1 | Registered: external instruction-fetch cycle in progress |
| rd_n | output | 1 | Registered active-low external read strobe |
| ports_as_bus | output | 1 | Shared ports must act as the address/data bus |

## Verification
The assertions assume that `req_kind` and `req_write` are known whenever `req_valid` is high. They also assume that `req_valid` is low during reset, so that the cycle after release starts idle. The stimulus follows both rules: it changes inputs only on the falling clock edge, keeps `req_valid` low under reset except in one deliberate reset-masking check, and draws kinds only from the four defined codes. Addresses are biased toward the program window, its edges and the register window, so that both strap settings reach every routing case.

// File: rtl/mar_pkg.sv
package mar_pkg;

    typedef enum logic [1:0] {
        ACC_INSTR  = 2'b00,
        ACC_DATA   = 2'b01,
        ACC_VECTOR = 2'b10,
        ACC_CONFIG = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic      valid;
        logic      write;
        acc_kind_e kind;
    } acc_ctl_s;

    typedef struct packed {
        logic ext_cyc;
        logic fetch;
        logic rd_n;
    } bus_stat_s;

    localparam bus_stat_s STAT_IDLE = '{ext_cyc: 1'b0, fetch: 1'b0, rd_n: 1'b1};

    // Next-cycle bus status for one access and its routing result.
    function automatic bus_stat_s stat_next(input acc_ctl_s c, input logic is_ext);
        bus_stat_s s;
        s         = STAT_IDLE;
        s.ext_cyc = c.valid && is_ext;
        s.rd_n    = !(c.valid && is_ext && !c.write);
        s.fetch   = c.valid && is_ext && !c.write && (c.kind == ACC_INSTR);
        return s;
    endfunction

endpackage

// File: rtl/mar_boot_latch.sv
module mar_boot_latch (
    input  logic clk,
    input  logic rst,
    input  logic strap_n,
    output logic win_internal
);
    logic held;

    always_ff @(posedge clk) begin
        if (rst) held <= strap_n;
    end

    assign win_internal = held;

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(held));
endmodule

// File: rtl/mar_addr_decode.sv
module mar_addr_decode #(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_LO = 24'hFF2000,
    parameter logic [ADDR_W-1:0] WIN_HI = 24'hFF9FFF,
    parameter logic [ADDR_W-1:0] REG_LO = 24'h000000,
    parameter logic [ADDR_W-1:0] REG_HI = 24'h0003FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_internal,
    output logic              is_ext
);
    localparam bit HAS_REG_WIN = (REG_HI >= REG_LO);

    logic in_win;
    logic in_reg;

    assign in_win = (addr >= WIN_LO) && (addr <= WIN_HI);

    generate
        if (HAS_REG_WIN) begin : g_regwin
            assign in_reg = (addr >= REG_LO) && (addr <= REG_HI);
        end else begin : g_noregwin
            assign in_reg = 1'b0;
        end
    endgenerate

    always_comb begin
        if (in_reg)      is_ext = 1'b0;
        else if (in_win) is_ext = !win_internal;
        else             is_ext = 1'b1;
    end

    // R3
    win_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !in_reg && (addr >= WIN_LO) && (addr <= WIN_HI) && !win_internal) |-> is_ext);

    // R4
    regwin_int_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && HAS_REG_WIN && (addr >= REG_LO) && (addr <= REG_HI)) |-> !is_ext);
endmodule

// File: rtl/mar_bus_status.sv
module mar_bus_status
    import mar_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_ctl_s  ctl,
    input  logic      is_ext,
    output bus_stat_s stat
);
    always_ff @(posedge clk) begin
        if (rst) stat <= STAT_IDLE;
        else     stat <= stat_next(ctl, is_ext);
    end

    // R6
    fetch_reads_chk: assert property (@(posedge clk) disable iff (rst)
        stat.fetch |-> (!stat.rd_n && stat.ext_cyc));

    // R7
    fetch_kind_chk: assert property (@(posedge clk) disable iff (rst)
        stat.fetch |-> ($past(ctl.kind) == ACC_INSTR && !$past(ctl.write)));

    // R9
    rd_ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        !stat.rd_n |-> stat.ext_cyc);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl.valid) |-> (stat.rd_n && !stat.fetch && !stat.ext_cyc));
endmodule

// File: rtl/mem_access_router.sv
module mem_access_router
    import mar_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_LO = 24'hFF2000,
    parameter logic [ADDR_W-1:0] WIN_HI = 24'hFF9FFF,
    parameter logic [ADDR_W-1:0] REG_LO = 24'h000000,
    parameter logic [ADDR_W-1:0] REG_HI = 24'h0003FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mem_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    output logic              cyc_ext,
    output logic              fetch_stat,
    output logic              rd_n,
    output logic              ports_as_bus
);
    logic      win_internal;
    logic      is_ext;
    acc_ctl_s  ctl;
    bus_stat_s stat;

    assign ctl.valid = req_valid;
    assign ctl.write = req_write;
    assign ctl.kind  = acc_kind_e'(req_kind);

    mar_boot_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .strap_n      (ext_mem_n),
        .win_internal (win_internal)
    );

    mar_addr_decode #(
        .ADDR_W (ADDR_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI),
        .REG_LO (REG_LO),
        .REG_HI (REG_HI)
    ) u_dec (
        .clk          (clk),
        .rst          (rst),
        .valid        (req_valid),
        .addr         (req_addr),
        .win_internal (win_internal),
        .is_ext       (is_ext)
    );

    mar_bus_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .is_ext (is_ext),
        .stat   (stat)
    );

    assign cyc_ext      = stat.ext_cyc;
    assign fetch_stat   = stat.fetch;
    assign rd_n         = stat.rd_n;
    assign ports_as_bus = !win_internal;

    // R5
    bus_ports_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr >= WIN_LO && req_addr <= WIN_HI
         && !(req_addr >= REG_LO && req_addr <= REG_HI)) |=> (cyc_ext == ports_as_bus));
endmodule

// File: tb/mem_access_router_tb_top.sv
`timescale 1ns/1ps
module mem_access_router_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mem_n = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic        cyc_ext, fetch_stat, rd_n, ports_as_bus;

    int checks = 0;
    int fails  = 0;
    logic cap;

    always #2.5 clk = ~clk;

    mem_access_router dut_i (
        .clk(clk), .rst(rst), .ext_mem_n(ext_mem_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_write(req_write), .cyc_ext(cyc_ext), .fetch_stat(fetch_stat),
        .rd_n(rd_n), .ports_as_bus(ports_as_bus)
    );

    function automatic logic ref_ext(input logic [23:0] a, input logic c);
        if (a <= 24'h0003FF) return 1'b0;
        if (a >= 24'hFF2000 && a <= 24'hFF9FFF) return !c;
        return 1'b1;
    endfunction

    function automatic string route_tag(input logic [23:0] a);
        if (a <= 24'h0003FF) return "R4";
        if (a >= 24'hFF2000 && a <= 24'hFF9FFF) return cap ? "R2" : "R3";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic v, input logic [23:0] a, input logic [1:0] k, input logic w);
        logic e;
        string ftag;
        string rtag;
        req_valid = v; req_addr = a; req_kind = k; req_write = w;
        @(negedge clk);
        e = v && ref_ext(a, cap);
        if (!v)       ftag = "R10";
        else if (!e)  ftag = "R8";
        else if (w)   ftag = "R7";
        else if (k == 2'b00) ftag = "R6";
        else          ftag = "R7";
        rtag = v ? "R9" : "R10";
        chk(v ? route_tag(a) : "R10", cyc_ext, e, "cyc_ext");
        chk(ftag, fetch_stat, e && !w && k == 2'b00, "fetch_stat");
        chk(rtag, rd_n, !(e && !w), "rd_n");
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst = 1'b1; ext_mem_n = strap; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; cap = strap;
        @(negedge clk);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [23:0] a;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: a = 24'hFF2000 + 24'($urandom_range(0, 24'h7FFF));
                1: a = 24'($urandom_range(0, 24'h3FF));
                2: a = (($urandom & 1) != 0) ? 24'hFF1FFF : 24'hFFA000;
                default: a = 24'($urandom);
            endcase
            if (($urandom & 7) == 0) ext_mem_n = $urandom;
            access(($urandom & 7) != 0, a, 2'($urandom), ($urandom & 3) == 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd17));
        cap = 1'b1;
        // R10: reset masks a live external read request
        rst = 1'b1; ext_mem_n = 1'b1;
        req_valid = 1'b1; req_addr = 24'h400000; req_kind = 2'b00; req_write = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", rd_n, 1'b1, "rd_n in reset");
        chk("R10", fetch_stat, 1'b0, "fetch_stat in reset");
        chk("R10", cyc_ext, 1'b0, "cyc_ext in reset");
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: strap change after release has no effect
        ext_mem_n = 1'b0;
        @(negedge clk);
        chk("R1", ports_as_bus, 1'b0, "ports_as_bus after strap change");
        chk("R5", ports_as_bus, 1'b0, "ports_as_bus internal mode");
        access(1, 24'hFF2000, 2'b00, 0);
        access(1, 24'hFF9FFF, 2'b01, 0);
        access(1, 24'hFF1FFF, 2'b00, 0);
        access(1, 24'hFFA000, 2'b00, 0);
        access(1, 24'h000100, 2'b00, 0);
        access(1, 24'h400000, 2'b10, 0);
        access(1, 24'h400000, 2'b00, 1);
        access(0, 24'h400000, 2'b00, 0);
        rand_run(400);

        do_reset(1'b0);
        ext_mem_n = 1'b1;
        @(negedge clk);
        chk("R5", ports_as_bus, 1'b1, "ports_as_bus external mode");
        chk("R1", ports_as_bus, 1'b1, "strap held low");
        access(1, 24'hFF2000, 2'b00, 0);
        access(1, 24'hFF9FFF, 2'b11, 0);
        access(1, 24'hFF5000, 2'b10, 0);
        access(1, 24'hFF5000, 2'b00, 1);
        access(1, 24'h0003FF, 2'b00, 0);
        access(1, 24'h000400, 2'b00, 0);
        rand_run(400);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule